// File: doc/BRIEF.md
# Whole-Array Erase Sequencer

This block runs a complete electrical erase of a byte-wide non-volatile memory attached to it and reports whether the erase succeeded. A host raises a start request. The sequencer then raises the programming supply to its erase level and selects the high-voltage level on address line 9. It fires a long strobe pulse that clears the whole array, and after each pulse it reads bytes back in verify mode to check whether they now hold all ones.

The verify walk moves upward from the first location. When a byte still reads back with a zero bit, the sequencer issues another whole-array pulse and resumes the walk at that same byte. It does not go back to the first location. A single pulse counter serves the whole run, so the run stops with a failure once the pulse budget is spent. When the last byte verifies, the supply returns to its normal level and every byte is read once more and compared with all ones. A one-cycle done strobe marks the end of the run. Pass or fail then stays asserted until the next start.

Pulse length and every setup and hold delay are counted in clock cycles. Each count is derived from a clock-rate parameter and a time in microseconds, so a simulation can shrink the long pulse by overriding that time.

Top module: `chip_erase_ctrl`

## Requirements
- R1: After reset the device pins are idle: chip enable, output enable and strobe are high (inactive), both high-voltage selects are low, and done, pass and fail are all 0.
- R2: Before every strobe falling edge, the following conditions hold together for at least SETUP_CYC cycles: erase supply selected, address-9 high voltage selected, chip enable low, output enable high, and address equal to 0 (so address bit 0 is low).
- R3: The strobe stays low for exactly PULSE_CYC cycles. After it rises, address 0 and both high-voltage selects are held for at least SETUP_CYC more cycles.
- R4: After each pulse, each verify read lasts SETUP_CYC cycles. During it the address is the current walk address, output enable is low, the strobe is high, the address-9 select is low and the erase supply stays selected. The read passes only when the data equals 0xFF.
- R5: A verify miss while fewer than MAX_PULSES pulses have been issued causes one more whole-array pulse, and the walk resumes at the same address. The pulse count is never cleared during a run, so a passing run issues max(1, largest per-byte pulse need) pulses.
- R6: A verify miss once MAX_PULSES pulses have been issued ends the run with fail, after exactly MAX_PULSES pulses.
- R7: When the last address verifies, the erase supply is deselected. Every address from 0 upward is then read for SETUP_CYC cycles each, and the run ends with pass if all of them read 0xFF.
- R8: A byte that differs from 0xFF in the final read stops the run at that byte, which is the last one read, and the run ends with fail.
- R9: Done is high for exactly one cycle at the end of a run, and at that point exactly one of pass and fail is set. Pass and fail keep their values until the next accepted start, which clears both.
- R10: A start request while a run is in progress is ignored. The run's pulses, reads and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, accepted only while idle |
| doneP | output | 1 | One-cycle end-of-run strobe |
| passOut | output | 1 | Run succeeded, held until next start |
| failOut | output | 1 | Run failed, held until next start |
| devAddr | output | ADDR_W | Memory address |
| devCeN | output | 1 | Memory chip enable, active low |
| devOeN | output | 1 | Memory output enable, active low |
| devStrobeN | output | 1 | Erase strobe, active low |
| vppEraseSel | output | 1 | Selects the erase level on the programming supply |
| a9EraseSel | output | 1 | Selects the high-voltage level on address line 9 |
| devData | input | DATA_W | Data read back from the memory |

## Verification
A behavioural memory model in the bench gives each byte a number of pulses it needs before it reads 0xFF, and it can make one byte misread only at the normal supply level. Four kinds of pattern are used. Pulse needs of all zero show that a single pulse is always issued. Random needs, including one stubborn byte near the end, separate "resume at the failing byte" from "restart the walk": the count of verify-read cycles differs between the two. A need of exactly the budget and one of the budget plus one separate pass from fail at the boundary. The byte that misreads only at the normal supply separates the final compare from the erase-verify pass. A start pulsed in mid-run must leave the pulse and read counts unchanged.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PSETUP,
    ST_PULSE,
    ST_PHOLD,
    ST_VWAIT,
    ST_RSETUP,
    ST_RWAIT,
    ST_FINISH
  } eraseState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrResult;
    logic addrClr;
    logic addrInc;
    logic pulseClr;
    logic pulseInc;
    logic timerLoad;
    logic timerLong;
    logic setPass;
    logic setFail;
  } ctrlStrobe_t;

endpackage

// File: rtl/chip_erase_dp.sv
module chip_erase_dp
  import chip_erase_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 20,
  parameter int PULSE_CYC  = 5000000,
  parameter int SETUP_CYC  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              addrZero,
  input  logic [DATA_W-1:0] devData,
  output logic [ADDR_W-1:0] devAddr,
  output logic              timerDone,
  output logic              byteOk,
  output logic              addrLast,
  output logic              pulseMaxed,
  output logic              passOut,
  output logic              failOut
);

  localparam int LONGEST = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int PC_W    = $clog2(MAX_PULSES + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [PC_W-1:0]   pulseCnt;
  logic [TMR_W-1:0]  tmr;

  // walk address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strb.addrClr) begin
      curAddr <= '0;
    end else if (strb.addrInc) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // run-wide pulse counter, never cleared between addresses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.pulseClr) begin
      pulseCnt <= '0;
    end else if (strb.pulseInc && (pulseCnt < PC_W'(MAX_PULSES))) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // shared down-counter for pulse width and setup/hold/access waits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strb.timerLoad) begin
      tmr <= strb.timerLong ? TMR_W'(PULSE_CYC - 1) : TMR_W'(SETUP_CYC - 1);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  // sticky result flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      passOut <= 1'b0;
      failOut <= 1'b0;
    end else if (strb.clrResult) begin
      passOut <= 1'b0;
      failOut <= 1'b0;
    end else begin
      if (strb.setPass) passOut <= 1'b1;
      if (strb.setFail) failOut <= 1'b1;
    end
  end

  assign timerDone  = (tmr == '0);
  assign byteOk     = (devData == {DATA_W{1'b1}});
  assign addrLast   = (curAddr == {ADDR_W{1'b1}});
  assign pulseMaxed = (pulseCnt >= PC_W'(MAX_PULSES));
  assign devAddr    = addrZero ? '0 : curAddr;

endmodule

// File: rtl/chip_erase_fsm.sv
module chip_erase_fsm
  import chip_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        timerDone,
  input  logic        byteOk,
  input  logic        addrLast,
  input  logic        pulseMaxed,
  output ctrlStrobe_t strb,
  output logic        addrZero,
  output logic        devCeN,
  output logic        devOeN,
  output logic        devStrobeN,
  output logic        vppEraseSel,
  output logic        a9EraseSel,
  output logic        doneP
);

  eraseState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt  = st;
    strb = '0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.clrResult = 1'b1;
          strb.addrClr   = 1'b1;
          strb.pulseClr  = 1'b1;
          strb.timerLoad = 1'b1;
          nxt            = ST_PSETUP;
        end
      end
      ST_PSETUP: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          strb.timerLong = 1'b1;
          nxt            = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (timerDone) begin
          strb.pulseInc  = 1'b1;
          strb.timerLoad = 1'b1;
          nxt            = ST_PHOLD;
        end
      end
      ST_PHOLD: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          nxt            = ST_VWAIT;
        end
      end
      ST_VWAIT: begin
        if (timerDone) begin
          if (byteOk) begin
            strb.timerLoad = 1'b1;
            if (addrLast) begin
              strb.addrClr = 1'b1;
              nxt          = ST_RSETUP;
            end else begin
              strb.addrInc = 1'b1;
            end
          end else if (pulseMaxed) begin
            strb.setFail = 1'b1;
            nxt          = ST_FINISH;
          end else begin
            strb.timerLoad = 1'b1;
            nxt            = ST_PSETUP;
          end
        end
      end
      ST_RSETUP: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          nxt            = ST_RWAIT;
        end
      end
      ST_RWAIT: begin
        if (timerDone) begin
          if (!byteOk) begin
            strb.setFail = 1'b1;
            nxt          = ST_FINISH;
          end else if (addrLast) begin
            strb.setPass = 1'b1;
            nxt          = ST_FINISH;
          end else begin
            strb.addrInc   = 1'b1;
            strb.timerLoad = 1'b1;
          end
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // pin decode from the state register
  always_comb begin
    logic hvPhase;
    hvPhase     = (st == ST_PSETUP) || (st == ST_PULSE) || (st == ST_PHOLD);
    addrZero    = hvPhase;
    a9EraseSel  = hvPhase;
    vppEraseSel = hvPhase || (st == ST_VWAIT);
    devCeN      = (st == ST_IDLE) || (st == ST_FINISH);
    devOeN      = !((st == ST_VWAIT) || (st == ST_RWAIT));
    devStrobeN  = (st != ST_PULSE);
    doneP       = (st == ST_FINISH);
  end

endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
  import chip_erase_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 20,
  parameter int CLK_MHZ    = 50,
  parameter int PULSE_US   = 100000,
  parameter int SETUP_US   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              doneP,
  output logic              passOut,
  output logic              failOut,
  output logic [ADDR_W-1:0] devAddr,
  output logic              devCeN,
  output logic              devOeN,
  output logic              devStrobeN,
  output logic              vppEraseSel,
  output logic              a9EraseSel,
  input  logic [DATA_W-1:0] devData
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int SETUP_CYC = (CLK_MHZ * SETUP_US > 0) ? CLK_MHZ * SETUP_US : 1;

  ctrlStrobe_t strb;
  logic timerDone, byteOk, addrLast, pulseMaxed, addrZero;

  chip_erase_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .timerDone  (timerDone),
    .byteOk     (byteOk),
    .addrLast   (addrLast),
    .pulseMaxed (pulseMaxed),
    .strb       (strb),
    .addrZero   (addrZero),
    .devCeN     (devCeN),
    .devOeN     (devOeN),
    .devStrobeN (devStrobeN),
    .vppEraseSel(vppEraseSel),
    .a9EraseSel (a9EraseSel),
    .doneP      (doneP)
  );

  chip_erase_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_PULSES(MAX_PULSES),
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrZero  (addrZero),
    .devData   (devData),
    .devAddr   (devAddr),
    .timerDone (timerDone),
    .byteOk    (byteOk),
    .addrLast  (addrLast),
    .pulseMaxed(pulseMaxed),
    .passOut   (passOut),
    .failOut   (failOut)
  );

endmodule

// File: rtl/chip_erase_checker.sv
module chip_erase_checker #(
  parameter int ADDR_W     = 17,
  parameter int MAX_PULSES = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneP,
  input logic              passOut,
  input logic              failOut,
  input logic [ADDR_W-1:0] devAddr,
  input logic              devCeN,
  input logic              devOeN,
  input logic              devStrobeN,
  input logic              vppEraseSel,
  input logic              a9EraseSel
);

  logic strobeQ;
  int   fallCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= 1'b1;
      fallCnt <= 0;
    end else begin
      strobeQ <= devStrobeN;
      if (doneP)                    fallCnt <= 0;
      else if (strobeQ && !devStrobeN) fallCnt <= fallCnt + 1;
    end
  end

  // R2: the strobe is only ever low with the full erase setup applied
  a_r2_strobe_conditions: assert property (@(posedge clk) disable iff (!rstN)
    !devStrobeN |-> (vppEraseSel && a9EraseSel && !devCeN && devOeN && devAddr == '0));

  // R3: the high-voltage address select survives the strobe rising edge
  a_r3_hold_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    (strobeQ == 1'b0 && devStrobeN) |-> (a9EraseSel && devAddr == '0));

  // R4: reads never overlap the strobe or the address-9 high voltage
  a_r4_read_isolated: assert property (@(posedge clk) disable iff (!rstN)
    !devOeN |-> (devStrobeN && !a9EraseSel && !devCeN));

  // R6: the pulse budget is never exceeded within a run
  a_r6_pulse_budget: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= MAX_PULSES);

  // R9: done lasts one cycle and carries exactly one verdict
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
  a_r9_done_verdict: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (passOut ^ failOut));

  // R9: a verdict only appears with done
  a_r9_pass_rises_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passOut) |-> doneP);

endmodule

bind chip_erase_ctrl chip_erase_checker #(
  .ADDR_W    (ADDR_W),
  .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .doneP      (doneP),
  .passOut    (passOut),
  .failOut    (failOut),
  .devAddr    (devAddr),
  .devCeN     (devCeN),
  .devOeN     (devOeN),
  .devStrobeN (devStrobeN),
  .vppEraseSel(vppEraseSel),
  .a9EraseSel (a9EraseSel)
);

// File: tb/chip_erase_ctrl_bench.sv
module chip_erase_ctrl_bench;

  localparam int ADDR_W    = 4;
  localparam int DEPTH     = 16;
  localparam int MAXP      = 20;
  localparam int PULSE_CYC = 12;
  localparam int SETUP_CYC = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, startReq;
  logic doneP, passOut, failOut;
  logic [ADDR_W-1:0] devAddr;
  logic devCeN, devOeN, devStrobeN, vppEraseSel, a9EraseSel;
  logic [7:0] devData;

  chip_erase_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(8), .MAX_PULSES(MAXP),
    .CLK_MHZ(1), .PULSE_US(PULSE_CYC), .SETUP_US(SETUP_CYC)
  ) u_chip_erase_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .doneP(doneP), .passOut(passOut), .failOut(failOut),
    .devAddr(devAddr), .devCeN(devCeN), .devOeN(devOeN),
    .devStrobeN(devStrobeN), .vppEraseSel(vppEraseSel),
    .a9EraseSel(a9EraseSel), .devData(devData)
  );

  int errs = 0;
  int total = 0;
  int needArr[DEPTH];
  int badIdx = -1;

  // monitor state
  logic monClr = 1'b0;
  int modelPulses, lowCnt, armCnt, widthErr, setupErr, holdErr, vCycles, fCycles;
  logic prevStrobe, holding;

  // memory model: a byte reads 0xFF once it has seen enough pulses
  always_comb begin
    if (!devCeN && !devOeN) begin
      if (modelPulses >= needArr[devAddr])
        devData = (!vppEraseSel && int'(devAddr) == badIdx) ? 8'hF0 : 8'hFF;
      else
        devData = 8'h7E;
    end else begin
      devData = 8'h00;
    end
  end

  always @(posedge clk) begin
    logic armed;
    if (monClr) begin
      modelPulses = 0; lowCnt = 0; armCnt = 0; widthErr = 0; setupErr = 0;
      holdErr = 0; vCycles = 0; fCycles = 0; prevStrobe = 1'b1; holding = 1'b0;
    end else begin
      armed = vppEraseSel && a9EraseSel && !devCeN && devOeN && devAddr == '0;
      if (!devOeN && vppEraseSel) vCycles++;
      if (!devOeN && !vppEraseSel && !devCeN) fCycles++;
      if (!devStrobeN) begin
        if (prevStrobe) begin
          if (armCnt < SETUP_CYC) setupErr++;
          modelPulses++;
          lowCnt = 1;
        end else begin
          lowCnt++;
        end
        armCnt = 0;
      end else begin
        if (!prevStrobe) begin
          if (lowCnt != PULSE_CYC) widthErr++;
          holding = 1'b1;
        end
        if (armed) armCnt++;
        else begin
          if (holding && armCnt < SETUP_CYC) holdErr++;
          holding = 1'b0;
          armCnt = 0;
        end
      end
      prevStrobe = devStrobeN;
    end
  end

  task automatic chkEq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected run outcome from the requirements
  task automatic predict(output int p, output int vr, output int fr, output bit ok);
    int a;
    bit fin, pulseNow;
    p = 0; vr = 0; fr = 0; ok = 1'b0; a = 0; fin = 1'b0; pulseNow = 1'b1;
    while (!fin) begin
      if (pulseNow) begin p++; pulseNow = 1'b0; end
      vr++;
      if (p >= needArr[a]) begin
        if (a == DEPTH - 1) begin fin = 1'b1; ok = 1'b1; end
        else a++;
      end else if (p >= MAXP) begin
        fin = 1'b1; ok = 1'b0;
      end else begin
        pulseNow = 1'b1;
      end
    end
    if (ok) begin
      if (badIdx >= 0) begin fr = badIdx + 1; ok = 1'b0; end
      else fr = DEPTH;
    end
  endtask

  task automatic runCase(string name, bit pokeBusy);
    int p, vr, fr, n;
    bit ok;
    predict(p, vr, fr, ok);
    @(negedge clk) monClr = 1'b1;
    @(negedge clk) monClr = 1'b0; startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chkEq({name, " R9 start clears verdict"}, int'(passOut) + int'(failOut), 0);
    n = 0;
    while (!doneP && n < 20000) begin
      @(negedge clk);
      n++;
      if (pokeBusy) startReq = (n == 40);
    end
    startReq = 1'b0;
    chkEq({name, " R9 done seen"}, int'(doneP), 1);
    chkEq({name, " R7/R8 pass"}, int'(passOut), int'(ok));
    chkEq({name, " R6/R8 fail"}, int'(failOut), int'(!ok));
    chkEq({name, " R5/R10 pulses"}, modelPulses, p);
    chkEq({name, " R4/R5 verify cycles"}, vCycles, vr * SETUP_CYC);
    chkEq({name, " R7 final read cycles"}, fCycles, fr * SETUP_CYC);
    chkEq({name, " R2 setup"}, setupErr, 0);
    chkEq({name, " R3 width"}, widthErr, 0);
    chkEq({name, " R3 hold"}, holdErr, 0);
    @(negedge clk);
    chkEq({name, " R9 done one cycle"}, int'(doneP), 0);
    chkEq({name, " R9 verdict held"}, int'(passOut), int'(ok));
    chkEq({name, " R1 pins idle after run"},
          int'(devCeN) + int'(devStrobeN) + int'(!vppEraseSel), 3);
    repeat (3) @(negedge clk);
  endtask

  task automatic fillRandom(int hi);
    for (int i = 0; i < DEPTH; i++) needArr[i] = $urandom_range(hi, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; startReq = 1'b0;
    for (int i = 0; i < DEPTH; i++) needArr[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1 ceN", int'(devCeN), 1);
    chkEq("R1 oeN", int'(devOeN), 1);
    chkEq("R1 strobeN", int'(devStrobeN), 1);
    chkEq("R1 hv selects", int'(vppEraseSel) + int'(a9EraseSel), 0);
    chkEq("R1 flags", int'(doneP) + int'(passOut) + int'(failOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCase("blank", 1'b0);                    // R5: one pulse minimum
    for (int t = 0; t < 3; t++) begin
      fillRandom(6);
      runCase("random", 1'b0);
    end
    fillRandom(3); needArr[DEPTH-1] = 9;
    runCase("late byte busy start R10", 1'b1);
    fillRandom(4); needArr[8] = MAXP;
    runCase("R6 at budget", 1'b0);
    fillRandom(4); needArr[5] = MAXP + 1;
    runCase("R6 over budget", 1'b0);
    fillRandom(2); badIdx = 7;
    runCase("R8 final miss", 1'b0);
    badIdx = -1;
    fillRandom(5);
    runCase("R7 after fail", 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule